// File: doc/BRIEF.md
# ATA Task File Register Block

This block is the host-facing register set of an ATA storage device. Two active-low chip selects, a three-bit register address and single-cycle read and write strobes pick one of the task-file registers: data, error/features, sector count, sector number, cylinder low and high, drive/head, status/command, alternate status/device control and drive address. The block stores the command parameters that the host writes. It builds the status, alternate-status and drive-address read values from flags driven by the command engine. It also holds the interrupt-pending flag, the interrupt mask, the software reset and the 8-bit transfer mode.

On the engine side the stored parameters are plain outputs. A write to the command register raises a one-cycle start strobe. Host data words leave on a valid/ready stream (`dwr_*`) through a one-word holding register. A host data write that arrives while that register still holds an unaccepted word is dropped, so the consumer must take each word before the host's next data write. Host data reads take the word on `drd_data` in the same cycle and pulse `drd_ready` to tell the producer to advance. The producer has no way to stall the host and must keep `drd_data` valid whenever the host may read it.

Top module: `ata_taskfile_regs`

## Requirements
- R1: With `host_cs_tf_n`=0 and `host_cs_ctl_n`=1, address 1 writes features and reads error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head and 7 writes command / reads status. Each written parameter reads back unchanged on the low byte, with the high byte 0, and appears on its engine-side output.
- R2: A drive/head read returns the stored value with bits 7 and 5 forced to 1. Bit 4 is the drive select and bits 3..0 the head.
- R3: The status value is {0, ready, write fault, seek done, data request, corrected, 0, error} from bit 7 down to bit 0. While `eng_busy` is 1 it reads exactly 0x80.
- R4: `eng_irq_set` makes an interrupt pending. A status read (address 7, task-file select) clears it in the next cycle. An alternate-status read (`host_cs_ctl_n`=0, address 6) leaves it pending.
- R5: A device-control write (`host_cs_ctl_n`=0, address 6) is accepted even while busy. Its bit 1 masks `intrq` while set and resets to 0. A pending interrupt that is masked reappears on `intrq` when the mask clears.
- R6: Device-control bit 2 holds `soft_rst` high until it is written 0. While the reset is held, the pending interrupt, the 8-bit mode, the error register and all task-file parameters read 0, and host writes to them are ignored.
- R7: A drive-address read (`host_cs_ctl_n`=0, address 7) returns bit 7 as 0 with `host_rdata_b7_float` high. Bit 6 is the inverse of `eng_writing`, bits 5..2 are the inverse of head bits 3..0, bit 1 is 0 when drive 1 is selected and bit 0 is 0 when drive 0 is selected.
- R8: The error register loads `eng_err_code` on `eng_err_we` with bits 5, 3 and 1 forced to 0.
- R9: `host_iocs16_n` is low while the data register (task-file select, address 0) is addressed and 8-bit mode is off, and high otherwise. In 8-bit mode, data moves on bits 7..0 only and the upper byte reads and is sent as 0.
- R10: While `eng_busy` is 1, host writes to the task-file parameters and the command register are ignored.
- R11: An accepted command write sets `cmd_code` and pulses `cmd_start` for exactly one cycle, in the cycle after the write.
- R12: A host data write loads the holding register and raises `dwr_valid`. `dwr_valid` and `dwr_data` stay unchanged until `dwr_ready`. A data write that arrives while a word is held and `dwr_ready` is low is dropped.
- R13: A host data read returns `drd_data` in the strobe cycle and raises `drd_ready` in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_tf_n | input | 1 | Task-file block select, active low |
| host_cs_ctl_n | input | 1 | Control block select, active low |
| host_addr | input | 3 | Register address |
| host_rd | input | 1 | Read strobe, one cycle per access |
| host_wr | input | 1 | Write strobe, one cycle per access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid during the read strobe, else 0 |
| host_rdata_b7_float | output | 1 | Bit 7 of the read value is undriven (drive-address read) |
| host_iocs16_n | output | 1 | 16-bit transfer indication, active low |
| intrq | output | 1 | Interrupt request to the host |
| eng_busy | input | 1 | Engine owns the registers |
| eng_rdy | input | 1 | Device ready |
| eng_dwf | input | 1 | Write fault |
| eng_dsc | input | 1 | Seek complete |
| eng_drq | input | 1 | Data request |
| eng_corr | input | 1 | Corrected data error |
| eng_err | input | 1 | Previous command ended in error |
| eng_writing | input | 1 | A write is in progress |
| eng_irq_set | input | 1 | Raise a pending interrupt |
| eng_err_we | input | 1 | Load the error register |
| eng_err_code | input | 8 | Error register value |
| eng_mode8_we | input | 1 | Load the 8-bit mode flag |
| eng_mode8_val | input | 1 | New 8-bit mode value |
| tf_features | output | 8 | Features parameter |
| tf_sec_cnt | output | 8 | Sector count parameter |
| tf_sec_num | output | 8 | Sector number parameter |
| tf_cyl_lo | output | 8 | Cylinder low parameter |
| tf_cyl_hi | output | 8 | Cylinder high parameter |
| tf_drv_head | output | 8 | Drive/head parameter as written |
| cmd_code | output | 8 | Last accepted command code |
| cmd_start | output | 1 | One-cycle command start strobe |
| soft_rst | output | 1 | Software reset held |
| irq_masked | output | 1 | Interrupt mask bit |
| mode8 | output | 1 | 8-bit data transfer mode |
| dwr_valid | output | 1 | Host write word held for the consumer |
| dwr_ready | input | 1 | Consumer accepts the held word |
| dwr_data | output | 16 | Held host write word |
| drd_data | input | 16 | Next word for host data reads |
| drd_ready | output | 1 | Host took `drd_data` this cycle |

## Verification
Assertions check several rules on every cycle. A masked interrupt never reaches `intrq`. An alternate-status read never drops a pending interrupt, and a status read always clears one unless a new one arrives. A busy status read shows only bit 7. Device-control writes land even while busy. `cmd_start` follows only an accepted command write. A held outgoing word stays stable until it is accepted, and 8-bit mode keeps `host_iocs16_n` high. Only the bench scenarios can show the full decode and readback, the exact drive-address and error encodings, the effects of the held soft reset, the parameter writes ignored while busy, and the dropped data write.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [3:0] {
    SEL_NONE    = 4'd0,
    SEL_DATA    = 4'd1,
    SEL_ERRFEAT = 4'd2,
    SEL_SCNT    = 4'd3,
    SEL_SNUM    = 4'd4,
    SEL_CYLLO   = 4'd5,
    SEL_CYLHI   = 4'd6,
    SEL_DRVHD   = 4'd7,
    SEL_STATCMD = 4'd8,
    SEL_ALTCTL  = 4'd9,
    SEL_DRVADDR = 4'd10
  } tf_sel_e;

  // error register: only bits 7,6,4,2,0 can be set
  localparam logic [REG_W-1:0] ERR_KEEP  = 8'hD5;
  // drive/head: bits 7 and 5 always read high
  localparam logic [REG_W-1:0] DH_FORCE  = 8'hA0;
  localparam logic [REG_W-1:0] STAT_BUSY = 8'h80;

  localparam int DC_NIEN_BIT = 1;
  localparam int DC_SRST_BIT = 2;
  localparam int DH_DRV_BIT  = 4;
endpackage

// File: rtl/ata_tf_decode.sv
module ata_tf_decode
  import ata_tf_pkg::*;
(
  input  logic              cs_tf_n,
  input  logic              cs_ctl_n,
  input  logic [ADDR_W-1:0] addr,
  output tf_sel_e           sel
);
  always_comb begin
    sel = SEL_NONE;
    if (!cs_tf_n && cs_ctl_n) begin
      case (addr)
        3'd0: sel = SEL_DATA;
        3'd1: sel = SEL_ERRFEAT;
        3'd2: sel = SEL_SCNT;
        3'd3: sel = SEL_SNUM;
        3'd4: sel = SEL_CYLLO;
        3'd5: sel = SEL_CYLHI;
        3'd6: sel = SEL_DRVHD;
        default: sel = SEL_STATCMD;
      endcase
    end else if (cs_tf_n && !cs_ctl_n) begin
      if (addr == 3'd6)      sel = SEL_ALTCTL;
      else if (addr == 3'd7) sel = SEL_DRVADDR;
    end
  end
endmodule

// File: rtl/ata_tf_ctrl.sv
module ata_tf_ctrl
  import ata_tf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  tf_sel_e          sel,
  input  logic             rd,
  input  logic             wr,
  input  logic [REG_W-1:0] wbyte,
  input  logic             irq_set,
  input  logic             mode8_we,
  input  logic             mode8_val,
  output logic             nien,
  output logic             srst,
  output logic             mode8,
  output logic             intrq
);
  logic pending;
  logic ctl_wr, stat_rd, alt_rd;

  assign ctl_wr  = wr && (sel == SEL_ALTCTL);
  assign stat_rd = rd && (sel == SEL_STATCMD);
  assign alt_rd  = rd && (sel == SEL_ALTCTL);

  // device control is never gated by busy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nien <= 1'b0;
      srst <= 1'b0;
    end else if (ctl_wr) begin
      nien <= wbyte[DC_NIEN_BIT];
      srst <= wbyte[DC_SRST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pending <= 1'b0;
    else if (srst)     pending <= 1'b0;
    else if (irq_set)  pending <= 1'b1;
    else if (stat_rd)  pending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mode8 <= 1'b0;
    else if (srst)     mode8 <= 1'b0;
    else if (mode8_we) mode8 <= mode8_val;
  end

  assign intrq = pending && !nien;

  AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    nien |-> !intrq); // R5
  AST_ALT_KEEPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_rd && pending && !srst) |=> pending); // R4
  AST_STAT_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !irq_set) |=> !pending); // R4
  AST_CTL_WR_WHILE_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (nien == $past(wbyte[DC_NIEN_BIT]))); // R5
endmodule

// File: rtl/ata_tf_regfile.sv
module ata_tf_regfile
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tf_sel_e           sel,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              srst,
  input  logic              mode8,
  input  logic              err_we,
  input  logic [REG_W-1:0]  err_code,
  input  logic              dwr_ready,
  output logic [REG_W-1:0]  features,
  output logic [REG_W-1:0]  sec_cnt,
  output logic [REG_W-1:0]  sec_num,
  output logic [REG_W-1:0]  cyl_lo,
  output logic [REG_W-1:0]  cyl_hi,
  output logic [REG_W-1:0]  drv_head,
  output logic [REG_W-1:0]  err_reg,
  output logic [REG_W-1:0]  cmd_code,
  output logic              cmd_start,
  output logic              dwr_valid,
  output logic [DATA_W-1:0] dwr_data
);
  localparam int HI_W = DATA_W - REG_W;

  logic             tf_wr_ok, cmd_wr, data_wr, hold_free;
  logic [REG_W-1:0] wbyte;

  assign wbyte     = wdata[REG_W-1:0];
  assign tf_wr_ok  = wr && !busy && !srst;
  assign cmd_wr    = tf_wr_ok && (sel == SEL_STATCMD);
  assign data_wr   = wr && !srst && (sel == SEL_DATA);
  assign hold_free = !dwr_valid || dwr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || srst) begin
      features <= '0;
      sec_cnt  <= '0;
      sec_num  <= '0;
      cyl_lo   <= '0;
      cyl_hi   <= '0;
      drv_head <= '0;
    end else if (tf_wr_ok) begin
      case (sel)
        SEL_ERRFEAT: features <= wbyte;
        SEL_SCNT:    sec_cnt  <= wbyte;
        SEL_SNUM:    sec_num  <= wbyte;
        SEL_CYLLO:   cyl_lo   <= wbyte;
        SEL_CYLHI:   cyl_hi   <= wbyte;
        SEL_DRVHD:   drv_head <= wbyte;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_reg <= '0;
    else if (srst)   err_reg <= '0;
    else if (err_we) err_reg <= err_code & ERR_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_code  <= '0;
      cmd_start <= 1'b0;
    end else begin
      cmd_start <= cmd_wr;
      if (cmd_wr) cmd_code <= wbyte;
    end
  end

  // one-word holding register toward the consumer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dwr_valid <= 1'b0;
      dwr_data  <= '0;
    end else if (data_wr && hold_free) begin
      dwr_valid <= 1'b1;
      dwr_data  <= mode8 ? {{HI_W{1'b0}}, wbyte} : wdata;
    end else if (dwr_ready) begin
      dwr_valid <= 1'b0;
    end
  end

  AST_CMD_START_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> $past(wr && (sel == SEL_STATCMD) && !busy)); // R11
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_valid && !dwr_ready) |=> (dwr_valid && $stable(dwr_data))); // R12
  AST_BUSY_NO_PARAM_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !srst) |=> $stable(sec_cnt)); // R10
endmodule

// File: rtl/ata_tf_rdmux.sv
module ata_tf_rdmux
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  tf_sel_e           sel,
  input  logic              rd,
  input  logic              mode8,
  input  logic              busy,
  input  logic              st_rdy,
  input  logic              st_dwf,
  input  logic              st_dsc,
  input  logic              st_drq,
  input  logic              st_corr,
  input  logic              st_err,
  input  logic              writing,
  input  logic [REG_W-1:0]  err_reg,
  input  logic [REG_W-1:0]  sec_cnt,
  input  logic [REG_W-1:0]  sec_num,
  input  logic [REG_W-1:0]  cyl_lo,
  input  logic [REG_W-1:0]  cyl_hi,
  input  logic [REG_W-1:0]  drv_head,
  input  logic [DATA_W-1:0] drd_data,
  output logic [DATA_W-1:0] rdata,
  output logic              b7_float,
  output logic              drd_ready,
  output logic              iocs16_n
);
  localparam int HI_W   = DATA_W - REG_W;
  localparam int HEAD_W = 4;

  logic [REG_W-1:0]  status, drv_addr;
  logic [DATA_W-1:0] value;
  logic              drv;

  assign status = busy ? STAT_BUSY
                       : {1'b0, st_rdy, st_dwf, st_dsc, st_drq, st_corr, 1'b0, st_err};

  assign drv = drv_head[DH_DRV_BIT];

  // inverted head bits land two places up
  for (genvar g = 0; g < HEAD_W; g++) begin : g_head_inv
    assign drv_addr[g+2] = ~drv_head[g];
  end
  assign drv_addr[7] = 1'b0;
  assign drv_addr[6] = ~writing;
  assign drv_addr[1] = ~drv;
  assign drv_addr[0] = drv;

  always_comb begin
    value = '0;
    case (sel)
      SEL_DATA:    value = mode8 ? {{HI_W{1'b0}}, drd_data[REG_W-1:0]} : drd_data;
      SEL_ERRFEAT: value = {{HI_W{1'b0}}, err_reg};
      SEL_SCNT:    value = {{HI_W{1'b0}}, sec_cnt};
      SEL_SNUM:    value = {{HI_W{1'b0}}, sec_num};
      SEL_CYLLO:   value = {{HI_W{1'b0}}, cyl_lo};
      SEL_CYLHI:   value = {{HI_W{1'b0}}, cyl_hi};
      SEL_DRVHD:   value = {{HI_W{1'b0}}, drv_head | DH_FORCE};
      SEL_STATCMD,
      SEL_ALTCTL:  value = {{HI_W{1'b0}}, status};
      SEL_DRVADDR: value = {{HI_W{1'b0}}, drv_addr};
      default:     value = '0;
    endcase
  end

  assign rdata     = rd ? value : '0;
  assign b7_float  = rd && (sel == SEL_DRVADDR);
  assign drd_ready = rd && (sel == SEL_DATA);
  assign iocs16_n  = !((sel == SEL_DATA) && !mode8);
endmodule

// File: rtl/ata_taskfile_regs.sv
module ata_taskfile_regs
  import ata_tf_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_tf_n,
  input  logic              host_cs_ctl_n,
  input  logic [2:0]        host_addr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rdata_b7_float,
  output logic              host_iocs16_n,
  output logic              intrq,
  input  logic              eng_busy,
  input  logic              eng_rdy,
  input  logic              eng_dwf,
  input  logic              eng_dsc,
  input  logic              eng_drq,
  input  logic              eng_corr,
  input  logic              eng_err,
  input  logic              eng_writing,
  input  logic              eng_irq_set,
  input  logic              eng_err_we,
  input  logic [7:0]        eng_err_code,
  input  logic              eng_mode8_we,
  input  logic              eng_mode8_val,
  output logic [7:0]        tf_features,
  output logic [7:0]        tf_sec_cnt,
  output logic [7:0]        tf_sec_num,
  output logic [7:0]        tf_cyl_lo,
  output logic [7:0]        tf_cyl_hi,
  output logic [7:0]        tf_drv_head,
  output logic [7:0]        cmd_code,
  output logic              cmd_start,
  output logic              soft_rst,
  output logic              irq_masked,
  output logic              mode8,
  output logic              dwr_valid,
  input  logic              dwr_ready,
  output logic [DATA_W-1:0] dwr_data,
  input  logic [DATA_W-1:0] drd_data,
  output logic              drd_ready
);
  tf_sel_e          sel;
  logic [REG_W-1:0] err_reg;

  ata_tf_decode u_decode (
    .cs_tf_n  (host_cs_tf_n),
    .cs_ctl_n (host_cs_ctl_n),
    .addr     (host_addr),
    .sel      (sel)
  );

  ata_tf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .rd        (host_rd),
    .wr        (host_wr),
    .wbyte     (host_wdata[REG_W-1:0]),
    .irq_set   (eng_irq_set),
    .mode8_we  (eng_mode8_we),
    .mode8_val (eng_mode8_val),
    .nien      (irq_masked),
    .srst      (soft_rst),
    .mode8     (mode8),
    .intrq     (intrq)
  );

  ata_tf_regfile #(.DATA_W(DATA_W)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .wr        (host_wr),
    .wdata     (host_wdata),
    .busy      (eng_busy),
    .srst      (soft_rst),
    .mode8     (mode8),
    .err_we    (eng_err_we),
    .err_code  (eng_err_code),
    .dwr_ready (dwr_ready),
    .features  (tf_features),
    .sec_cnt   (tf_sec_cnt),
    .sec_num   (tf_sec_num),
    .cyl_lo    (tf_cyl_lo),
    .cyl_hi    (tf_cyl_hi),
    .drv_head  (tf_drv_head),
    .err_reg   (err_reg),
    .cmd_code  (cmd_code),
    .cmd_start (cmd_start),
    .dwr_valid (dwr_valid),
    .dwr_data  (dwr_data)
  );

  ata_tf_rdmux #(.DATA_W(DATA_W)) u_rdmux (
    .sel       (sel),
    .rd        (host_rd),
    .mode8     (mode8),
    .busy      (eng_busy),
    .st_rdy    (eng_rdy),
    .st_dwf    (eng_dwf),
    .st_dsc    (eng_dsc),
    .st_drq    (eng_drq),
    .st_corr   (eng_corr),
    .st_err    (eng_err),
    .writing   (eng_writing),
    .err_reg   (err_reg),
    .sec_cnt   (tf_sec_cnt),
    .sec_num   (tf_sec_num),
    .cyl_lo    (tf_cyl_lo),
    .cyl_hi    (tf_cyl_hi),
    .drv_head  (tf_drv_head),
    .drd_data  (drd_data),
    .rdata     (host_rdata),
    .b7_float  (host_rdata_b7_float),
    .drd_ready (drd_ready),
    .iocs16_n  (host_iocs16_n)
  );

  AST_BUSY_STATUS_ONLY_BSY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && eng_busy && !host_cs_tf_n && host_cs_ctl_n && (host_addr == 3'd7))
      |-> (host_rdata[6:0] == 7'd0 && host_rdata[7])); // R3
  AST_MODE8_NO_IOCS16: assert property (@(posedge clk) disable iff (!rst_n)
    mode8 |-> host_iocs16_n); // R9
endmodule

// File: tb/ata_taskfile_regs_tb.sv
module ata_taskfile_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_cs_tf_n = 1'b1, host_cs_ctl_n = 1'b1;
  logic [2:0]  host_addr = '0;
  logic        host_rd = 1'b0, host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_rdata_b7_float, host_iocs16_n, intrq;
  logic        eng_busy = 0, eng_rdy = 1, eng_dwf = 0, eng_dsc = 0, eng_drq = 0;
  logic        eng_corr = 0, eng_err = 0, eng_writing = 0, eng_irq_set = 0;
  logic        eng_err_we = 0, eng_mode8_we = 0, eng_mode8_val = 0;
  logic [7:0]  eng_err_code = '0;
  logic [7:0]  tf_features, tf_sec_cnt, tf_sec_num, tf_cyl_lo, tf_cyl_hi, tf_drv_head, cmd_code;
  logic        cmd_start, soft_rst, irq_masked, mode8, dwr_valid, drd_ready;
  logic        dwr_ready = 1'b0;
  logic [15:0] dwr_data;
  logic [15:0] drd_data = '0;

  int n_tests = 0, n_fail = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  ata_taskfile_regs u_dut (.*);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one-cycle read strobe, expectation into the scoreboard
  task automatic hrd(input logic ctl, input logic [2:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    host_cs_tf_n = ctl; host_cs_ctl_n = !ctl; host_addr = a; host_rd = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    host_rd = 1'b0; host_cs_tf_n = 1'b1; host_cs_ctl_n = 1'b1;
  endtask

  task automatic hwr(input logic ctl, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_cs_tf_n = ctl; host_cs_ctl_n = !ctl; host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; host_cs_tf_n = 1'b1; host_cs_ctl_n = 1'b1;
  endtask

  // monitor: pops and compares while a read strobe is high
  always begin
    @(negedge clk);
    #5;
    if (host_rd) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL scoreboard empty actual=%h expected=none", host_rdata);
      end else begin
        check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset outputs", {11'd0, intrq, soft_rst, cmd_start, dwr_valid, irq_masked}, 16'd0);
    hrd(1'b0, 3'd7, 16'h0040, "R3 status after reset");
    hrd(1'b0, 3'd6, 16'h00A0, "R2 drive/head after reset");
    hrd(1'b1, 3'd7, 16'h007E, "R7 drive address reset");

    // R1 parameter writes and readback
    hwr(1'b0, 3'd1, 16'h009A);
    hwr(1'b0, 3'd2, 16'h0012);
    hwr(1'b0, 3'd3, 16'h0034);
    hwr(1'b0, 3'd4, 16'h0056);
    hwr(1'b0, 3'd5, 16'h0078);
    hwr(1'b0, 3'd6, 16'h001B);
    check("R1 features out", {8'd0, tf_features}, 16'h009A);
    check("R1 engine params", {tf_cyl_hi, tf_cyl_lo}, 16'h7856);
    hrd(1'b0, 3'd2, 16'h0012, "R1 sector count");
    hrd(1'b0, 3'd3, 16'h0034, "R1 sector number");
    hrd(1'b0, 3'd4, 16'h0056, "R1 cylinder low");
    hrd(1'b0, 3'd5, 16'h0078, "R1 cylinder high");
    hrd(1'b0, 3'd6, 16'h00BB, "R2 drive/head forced bits");
    hrd(1'b1, 3'd7, 16'h0051, "R7 drive address drive1 head B");
    eng_writing = 1'b1;
    hrd(1'b1, 3'd7, 16'h0011, "R7 drive address writing");
    @(negedge clk);
    host_cs_tf_n = 1'b1; host_cs_ctl_n = 1'b0; host_addr = 3'd7; host_rd = 1'b1;
    exp_q.push_back(16'h0011); tag_q.push_back("R7 float readback");
    #5 check("R7 bit7 float", {15'd0, host_rdata_b7_float}, 16'd1);
    @(negedge clk);
    host_rd = 1'b0; host_cs_ctl_n = 1'b1; eng_writing = 1'b0;

    // R3 status layout and busy masking
    eng_dwf = 1; eng_drq = 1; eng_err = 1;
    hrd(1'b0, 3'd7, 16'h0069, "R3 status layout");
    eng_busy = 1;
    hrd(1'b1, 3'd6, 16'h0080, "R3 busy alt status");
    eng_dwf = 0; eng_drq = 0; eng_err = 0;

    // R10 writes ignored while busy
    hwr(1'b0, 3'd2, 16'h00FF);
    hwr(1'b0, 3'd7, 16'h00C4);
    check("R10 busy command no start", {15'd0, cmd_start}, 16'd0);
    eng_busy = 0;
    hrd(1'b0, 3'd2, 16'h0012, "R10 sector count kept");

    // R11 command strobe
    hwr(1'b0, 3'd7, 16'h0020);
    #1 check("R11 cmd_start high", {15'd0, cmd_start}, 16'd1);
    check("R11 cmd_code", {8'd0, cmd_code}, 16'h0020);
    @(negedge clk);
    check("R11 cmd_start one cycle", {15'd0, cmd_start}, 16'd0);

    // R4 interrupt clear rules
    @(negedge clk); eng_irq_set = 1; @(negedge clk); eng_irq_set = 0;
    check("R4 intrq raised", {15'd0, intrq}, 16'd1);
    hrd(1'b1, 3'd6, 16'h0040, "R4 alt status value");
    check("R4 alt read keeps irq", {15'd0, intrq}, 16'd1);
    hrd(1'b0, 3'd7, 16'h0040, "R4 status value");
    check("R4 status read clears irq", {15'd0, intrq}, 16'd0);

    // R5 device control while busy, masking
    eng_busy = 1;
    hwr(1'b1, 3'd6, 16'h0002);
    check("R5 mask set while busy", {15'd0, irq_masked}, 16'd1);
    eng_busy = 0;
    @(negedge clk); eng_irq_set = 1; @(negedge clk); eng_irq_set = 0;
    check("R5 masked intrq low", {15'd0, intrq}, 16'd0);
    hwr(1'b1, 3'd6, 16'h0000);
    check("R5 unmask shows pending", {15'd0, intrq}, 16'd1);
    hrd(1'b0, 3'd7, 16'h0040, "R4 status clear again");

    // R8 error register masking
    @(negedge clk); eng_err_code = 8'hFF; eng_err_we = 1; @(negedge clk); eng_err_we = 0;
    hrd(1'b0, 3'd1, 16'h00D5, "R8 error bits 5,3,1 zero");

    // R6 soft reset held
    hwr(1'b1, 3'd6, 16'h0004);
    check("R6 soft_rst high", {15'd0, soft_rst}, 16'd1);
    @(negedge clk); eng_irq_set = 1; @(negedge clk); eng_irq_set = 0;
    check("R6 no irq during reset", {15'd0, intrq}, 16'd0);
    hwr(1'b0, 3'd2, 16'h0055);
    hrd(1'b0, 3'd2, 16'h0000, "R6 sector count cleared");
    hrd(1'b0, 3'd1, 16'h0000, "R6 error cleared");
    repeat (2) @(negedge clk);
    check("R6 still held", {15'd0, soft_rst}, 16'd1);
    hwr(1'b1, 3'd6, 16'h0000);
    check("R6 released", {15'd0, soft_rst}, 16'd0);

    // R9 / R13 data access width
    @(negedge clk);
    host_cs_tf_n = 0; host_addr = 3'd0;
    #5 check("R9 iocs16 low 16-bit", {15'd0, host_iocs16_n}, 16'd0);
    host_cs_tf_n = 1;
    drd_data = 16'hBEEF;
    @(negedge clk);
    host_cs_tf_n = 0; host_addr = 3'd0; host_rd = 1;
    exp_q.push_back(16'hBEEF); tag_q.push_back("R13 data read word");
    #5 check("R13 drd_ready in strobe", {15'd0, drd_ready}, 16'd1);
    @(negedge clk); host_rd = 0; host_cs_tf_n = 1;
    #1 check("R13 drd_ready drops", {15'd0, drd_ready}, 16'd0);
    @(negedge clk); eng_mode8_val = 1; eng_mode8_we = 1; @(negedge clk); eng_mode8_we = 0;
    host_cs_tf_n = 0; host_addr = 3'd0;
    #5 check("R9 iocs16 high in mode8", {15'd0, host_iocs16_n}, 16'd1);
    host_cs_tf_n = 1;
    hrd(1'b0, 3'd0, 16'h00EF, "R9 mode8 read low byte");
    hwr(1'b0, 3'd0, 16'h1234);
    check("R9 mode8 write low byte", dwr_data, 16'h0034);
    @(negedge clk); dwr_ready = 1; @(negedge clk); dwr_ready = 0;
    check("R12 accepted clears valid", {15'd0, dwr_valid}, 16'd0);
    @(negedge clk); eng_mode8_val = 0; eng_mode8_we = 1; @(negedge clk); eng_mode8_we = 0;

    // R12 holding register back-pressure
    hwr(1'b0, 3'd0, 16'hCAFE);
    check("R12 valid after write", {15'd0, dwr_valid}, 16'd1);
    hwr(1'b0, 3'd0, 16'h1111);
    check("R12 held word kept, second dropped", dwr_data, 16'hCAFE);
    @(negedge clk); dwr_ready = 1; @(negedge clk); dwr_ready = 0;
    check("R12 valid clears on ready", {15'd0, dwr_valid}, 16'd0);

    repeat (2) @(negedge clk);
    check("scoreboard drained", exp_q.size()[15:0], 16'd0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule